// File: doc/BRIEF.md
# Framed Serial Readback Port

This block is the slave side of the four-wire serial port of a position-sensing converter. An active-low chip select and a frame-sync strobe bound each transfer. A serial clock shifts data out and in. Two mode inputs choose what a frame carries. In position or velocity mode a frame returns a 16-bit word, most significant bit first, followed by an 8-bit fault byte. In configuration mode every frame is one byte: a byte with its top bit set selects a register address, the next full byte writes that register, and every configuration frame returns the currently addressed register.

The serial pins are sampled on the system clock `clk_i`. The master must hold each serial pin level for at least one system clock. Outside a frame the data output is released, shown by `sdo_oe_o` low. The register file itself sits outside the block and is reached through a write strobe, an address and a read-data input.

Top module: `serial_readback_port`

## Requirements
- R1: A frame starts only when frame-sync falls while `csn_i` is low and `sel_serial_ni` is low; a frame-sync fall under any other condition leaves `sdo_oe_o` low.
- R2: `sdo_oe_o` rises one clock after the qualifying frame-sync fall and drops one clock after frame-sync rises; while `sdo_oe_o` is low, `sdo_o` is 0.
- R3: With mode 2'b00, the frame returns `pos_i` MSB first, then `fault_i` MSB first, 24 bits in total.
- R4: With mode 2'b01, the frame returns `vel_i` MSB first, then `fault_i` MSB first.
- R5: The returned word, fault byte and mode are the ones present at the frame-sync fall; changes during the frame have no effect on that frame.
- R6: The first bit is on `sdo_o` from the frame start; each later bit appears after a rising edge of `sclk_i`, the first rising edge of a frame excepted, and `sdo_o` holds between those edges.
- R7: Rising edges beyond the 24th shift out 0.
- R8: A frame may end after 16 bits; the next frame reloads and starts again from its first bit.
- R9: In configuration mode (2'b11), a frame of exactly 8 bits captured on falling `sclk_i` edges whose first bit is 1, arriving when no data byte is pending, sets `cfg_addr_o` to the byte's low 7 bits and writes nothing.
- R10: The next exactly-8-bit configuration frame after an address frame is data, whatever its top bit: `cfg_wr_o` pulses for one clock as `sdo_oe_o` drops, with `cfg_wdata_o` holding the byte and `cfg_addr_o` the address.
- R11: Every configuration frame returns `cfg_rdata_i` for the current `cfg_addr_o` MSB first, then zeros.
- R12: A configuration frame with a bit count other than 8, or an 8-bit frame with top bit 0 while no data byte is pending, changes neither the address nor the register file.
- R13: With mode 2'b10 the frame returns only zeros and writes or addresses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all serial pins sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_serial_ni | input | 1 | Low selects the serial interface |
| csn_i | input | 1 | Active-low chip select |
| fsync_i | input | 1 | Frame-sync strobe; falling edge opens a frame, rising edge closes it |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data in, captured on falling `sclk_i` |
| mode_i | input | 2 | 00 position, 01 velocity, 10 unused, 11 configuration |
| pos_i | input | 16 | Current position word |
| vel_i | input | 16 | Current velocity word |
| fault_i | input | 8 | Current fault flags |
| cfg_rdata_i | input | 8 | Register file contents at `cfg_addr_o` |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | High while the data output is driven |
| cfg_wr_o | output | 1 | One-clock register write strobe |
| cfg_addr_o | output | 7 | Current register address |
| cfg_wdata_o | output | 8 | Register write data |

## Verification
Every serial pin event takes effect at the first rising `clk_i` edge that samples it. The bench changes one pin per cycle on the falling system edge and reads the results on the next falling edge. A frame opens one clock after the frame-sync fall. A new bit appears one clock after each counted serial-clock rise, so the bench compares it just before it drives the serial clock low, which is where a master samples. The write strobe and the output-enable drop appear one clock after frame-sync rises. The write monitor compares every strobe against its queue on the falling edge, and the bench checks the address after the frame has closed.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [1:0] {
    MODE_POS = 2'b00,
    MODE_VEL = 2'b01,
    MODE_RSV = 2'b10,
    MODE_CFG = 2'b11
  } rsp_mode_e;
endpackage

// File: rtl/rsp_edge_det.sv
module rsp_edge_det #(
  parameter int unsigned   N       = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/rsp_tx_shift.sv
module rsp_tx_shift #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_val_i,
  input  logic               active_i,
  input  logic               shift_edge_i,
  output logic               sdo_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;

  // first rising edge of a frame presents bit 0, later edges advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= load_val_i;
      cnt_q <= '0;
    end else if (active_i && shift_edge_i) begin
      if (cnt_q != '0)     sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sdo_o = sr_q[FRAME_W-1];
endmodule

// File: rtl/rsp_rx_shift.sv
module rsp_rx_shift #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              active_i,
  input  logic              cap_edge_i,
  input  logic              sdi_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (active_i && cap_edge_i) begin
      sr_q <= {sr_q[BYTE_W-2:0], sdi_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign byte_o = sr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rsp_cfg_ctrl.sv
module rsp_cfg_ctrl #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              wr_q;
  logic              await_q;
  logic              full_byte;

  assign full_byte = (cnt_i == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      await_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (commit_i && full_byte) begin
        if (await_q) begin
          wr_q    <= 1'b1;
          wdata_q <= byte_i;
          await_q <= 1'b0;
        end else if (byte_i[BYTE_W-1]) begin
          addr_q  <= byte_i[ADDR_W-1:0];
          await_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign wr_o    = wr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/serial_readback_port.sv
module serial_readback_port
  import rsp_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FLT_W  = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_serial_ni,
  input  logic              csn_i,
  input  logic              fsync_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] pos_i,
  input  logic [WORD_W-1:0] vel_i,
  input  logic [FLT_W-1:0]  fault_i,
  input  logic [BYTE_W-1:0] cfg_rdata_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              cfg_wr_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [BYTE_W-1:0] cfg_wdata_o
);
  localparam int unsigned FRAME_W = WORD_W + FLT_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam int unsigned PAD_W   = FRAME_W - BYTE_W;

  // edge bit 1: fsync, bit 0: sclk
  logic [1:0] rise, fall;
  logic       fs_rise, fs_fall, sc_rise, sc_fall;

  rsp_edge_det #(.N(2), .RST_VAL(2'b10)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({fsync_i, sclk_i}),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign fs_rise = rise[1];
  assign fs_fall = fall[1];
  assign sc_rise = rise[0];
  assign sc_fall = fall[0];

  logic      active_q;
  rsp_mode_e mode_q;
  logic      start, stop;

  assign start = fs_fall & ~csn_i & ~sel_serial_ni & ~active_q;
  assign stop  = active_q & (fs_rise | csn_i | sel_serial_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= MODE_POS;
    end else if (start) begin
      active_q <= 1'b1;
      mode_q   <= rsp_mode_e'(mode_i);
    end else if (stop) begin
      active_q <= 1'b0;
    end
  end

  logic [FRAME_W-1:0] load_val;

  always_comb begin
    unique case (rsp_mode_e'(mode_i))
      MODE_POS: load_val = {pos_i, fault_i};
      MODE_VEL: load_val = {vel_i, fault_i};
      MODE_CFG: load_val = {cfg_rdata_i, {PAD_W{1'b0}}};
      default:  load_val = '0;
    endcase
  end

  logic tx_bit;

  rsp_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .load_val_i  (load_val),
    .active_i    (active_q),
    .shift_edge_i(sc_rise),
    .sdo_o       (tx_bit)
  );

  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  rx_cnt;

  rsp_rx_shift #(.BYTE_W(BYTE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start),
    .active_i  (active_q),
    .cap_edge_i(sc_fall),
    .sdi_i     (sdi_i),
    .byte_o    (rx_byte),
    .cnt_o     (rx_cnt)
  );

  rsp_cfg_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(stop && (mode_q == MODE_CFG)),
    .cnt_i   (rx_cnt),
    .byte_i  (rx_byte),
    .addr_o  (cfg_addr_o),
    .wr_o    (cfg_wr_o),
    .wdata_o (cfg_wdata_o)
  );

  assign sdo_oe_o = active_q;
  assign sdo_o    = active_q & tx_bit;
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_serial_ni,
  input logic              csn_i,
  input logic              fsync_i,
  input logic              sclk_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              cfg_wr_o,
  input logic [ADDR_W-1:0] cfg_addr_o
);
  p_oe_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(!fsync_i && !csn_i && !sel_serial_ni));

  p_oe_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdo_oe_o) |-> $past(fsync_i || csn_i || sel_serial_ni));

  p_sdo_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  p_sdo_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !($past(sclk_i) && !$past(sclk_i, 2)))
      |-> $stable(sdo_o));

  p_wr_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o);

  p_wr_at_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> (!sdo_oe_o && $past(sdo_oe_o)));

  p_addr_at_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_addr_o) |-> (!sdo_oe_o && $past(sdo_oe_o)));
endmodule

bind serial_readback_port rsp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_serial_ni(sel_serial_ni),
  .csn_i        (csn_i),
  .fsync_i      (fsync_i),
  .sclk_i       (sclk_i),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o),
  .cfg_wr_o     (cfg_wr_o),
  .cfg_addr_o   (cfg_addr_o)
);

// File: tb/serial_readback_port_tb.sv
module serial_readback_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b0;
  logic        csn = 1'b1;
  logic        fsync = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] pos = '0;
  logic [15:0] vel = '0;
  logic [7:0]  fault = '0;
  logic [7:0]  cfg_rdata;
  logic        sdo, sdo_oe, cfg_wr;
  logic [6:0]  cfg_addr;
  logic [7:0]  cfg_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_readback_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_serial_ni(sel_n), .csn_i(csn),
    .fsync_i(fsync), .sclk_i(sclk), .sdi_i(sdi), .mode_i(mode),
    .pos_i(pos), .vel_i(vel), .fault_i(fault), .cfg_rdata_i(cfg_rdata),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_wr_o(cfg_wr),
    .cfg_addr_o(cfg_addr), .cfg_wdata_o(cfg_wdata)
  );

  // register file model behind the port
  logic [7:0] regs [128];
  initial for (int a = 0; a < 128; a++) regs[a] = 8'(a * 3 + 1);
  always @(posedge clk) if (cfg_wr) regs[cfg_addr] <= cfg_wdata;
  assign cfg_rdata = regs[cfg_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // scoreboard queues
  typedef struct packed { logic [6:0] a; logic [7:0] d; } wr_t;
  wr_t   exp_wr_q[$];
  logic  exp_bit_q[$];
  string exp_tag_q[$];
  event  sample_ev;

  always @(sample_ev) begin
    logic  e;
    string t;
    if (exp_bit_q.size() == 0) begin
      chk("R6 no expected bit", 32'(sdo), 32'hx);
    end else begin
      e = exp_bit_q.pop_front();
      t = exp_tag_q.pop_front();
      chk(t, 32'(sdo), 32'(e));
    end
  end

  always @(negedge clk) begin
    wr_t w;
    if (rst_n && cfg_wr) begin
      if (exp_wr_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R12: unexpected write actual addr %0h data %0h expected none",
                 cfg_addr, cfg_wdata);
      end else begin
        w = exp_wr_q.pop_front();
        chk("R10 write addr", 32'(cfg_addr), 32'(w.a));
        chk("R10 write data", 32'(cfg_wdata), 32'(w.d));
      end
    end
  end

  // one frame: tx/exp are MSB-first 24-bit patterns, bits beyond 24 are 0
  task automatic frame(input logic [1:0] m, input int nbits, input logic [23:0] tx,
                       input logic [23:0] exp, input string tag);
    mode = m;
    csn = 1'b0;
    step();
    fsync = 1'b0;
    step();
    chk("R2 oe after fsync fall", 32'(sdo_oe), 32'd1);
    if (nbits > 0) chk("R6 first bit before sclk", 32'(sdo), 32'(exp[23]));
    // R5: inputs move after the frame start
    pos = ~pos;
    vel = ~vel;
    fault = ~fault;
    for (int i = 0; i < nbits; i++) begin
      exp_bit_q.push_back(i < 24 ? exp[23-i] : 1'b0);
      exp_tag_q.push_back(tag);
      sdi = (i < 24) ? tx[23-i] : 1'b0;
      sclk = 1'b1;
      step();
      ->sample_ev;
      sclk = 1'b0;
      step();
    end
    fsync = 1'b1;
    step();
    chk("R2 oe after fsync rise", 32'(sdo_oe), 32'd0);
    chk("R2 sdo idle", 32'(sdo), 32'd0);
    csn = 1'b1;
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("reset oe", 32'(sdo_oe), 32'd0);
    chk("reset sdo", 32'(sdo), 32'd0);
    chk("reset wr", 32'(cfg_wr), 32'd0);
    chk("reset addr", 32'(cfg_addr), 32'd0);

    // R1: serial not selected
    sel_n = 1'b1; csn = 1'b0; step();
    fsync = 1'b0; step(); step();
    chk("R1 parallel selected", 32'(sdo_oe), 32'd0);
    fsync = 1'b1; csn = 1'b1; step();
    sel_n = 1'b0; step();
    // R1: chip select high
    fsync = 1'b0; step(); step();
    chk("R1 chip select high", 32'(sdo_oe), 32'd0);
    fsync = 1'b1; step();

    // R3 R5 R7: position, full frame plus two extra clocks
    pos = 16'hA5C3; fault = 8'h5A;
    frame(2'b00, 26, 24'h0, {16'hA5C3, 8'h5A}, "R3 R5 R7 position");

    // R4 R8: velocity, ended after 16 bits
    vel = 16'h8001; fault = 8'h81;
    frame(2'b01, 16, 24'h0, {16'h8001, 8'h81}, "R4 R8 velocity");
    // R8: next frame starts from bit 0
    pos = 16'h0F0F; fault = 8'hF0;
    frame(2'b00, 24, 24'h0, {16'h0F0F, 8'hF0}, "R8 reload");

    // R13: unused mode
    frame(2'b10, 24, {8'h85, 16'h0}, 24'h0, "R13 unused mode");
    chk("R13 addr untouched", 32'(cfg_addr), 32'd0);

    // R9: address frame, returns reg 0
    frame(2'b11, 8, {8'h85, 16'h0}, {8'h01, 16'h0}, "R11 read at addr 0");
    chk("R9 address set", 32'(cfg_addr), 32'd5);

    // R10: data frame
    exp_wr_q.push_back({7'd5, 8'h3C});
    frame(2'b11, 8, {8'h3C, 16'h0}, {8'h10, 16'h0}, "R11 read at addr 5");
    frame(2'b11, 8, 24'h0, {8'h3C, 16'h0}, "R11 read back written");
    chk("R12 top-bit-0 byte ignored", 32'(cfg_addr), 32'd5);

    // R12: wrong length frame
    frame(2'b11, 12, {8'h87, 16'h0}, {8'h3C, 16'h0}, "R12 long frame");
    chk("R12 long frame ignored", 32'(cfg_addr), 32'd5);

    frame(2'b11, 8, {8'h87, 16'h0}, {8'h3C, 16'h0}, "R11 read before readdress");
    chk("R9 second address", 32'(cfg_addr), 32'd7);
    frame(2'b11, 5, {8'hFF, 16'h0}, {8'h16, 16'h0}, "R12 short frame");
    chk("R12 short frame no readdress", 32'(cfg_addr), 32'd7);

    // R10: data byte with top bit set is still data
    exp_wr_q.push_back({7'd7, 8'h9A});
    frame(2'b11, 8, {8'h9A, 16'h0}, {8'h16, 16'h0}, "R11 read at addr 7");
    frame(2'b11, 8, 24'h0, {8'h9A, 16'h0}, "R10 R11 read back");
    chk("R10 addr kept after write", 32'(cfg_addr), 32'd7);

    step();
    chk("R10 writes all seen", exp_wr_q.size(), 32'd0);
    chk("R6 bits all sampled", exp_bit_q.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule